// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block picks which of the DMA channels may use the bus next. Each channel raises a request line. When the arbiter is idle, it grants the highest-ranked requesting channel on the next clock edge. It holds that grant until the channel pulses the unit-transfer-done strobe together with its channel number. A unit transfer is one byte, word or longword.

A two-bit mode input selects the scheme. In fixed mode the ranking is always channel 0 first and channel 3 last. In round-robin mode, every completed unit transfer moves the finishing channel to the bottom of the ranking. The channels that were ranked above it move down with it, so the whole ranking rotates.

The ranking is held as a single pointer to the top-ranked channel and is output for observation. A configuration-error flag warns when round-robin is selected while the per-channel bus modes mix burst and cycle-steal.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is active and on the first cycle after it, `grant_o` is zero and the ranking is channel 0 > 1 > 2 > 3. `order_o` holds one 2-bit channel number per rank, with rank 0 (highest) in bits [1:0], so this ranking reads 8'hE4.
- R2: `mode_i` = 2'b01 selects round-robin, and every other value selects fixed mode. In fixed mode the ranking stays 0 > 1 > 2 > 3 and done strobes leave it unchanged.
- R3: In round-robin mode, a done strobe for channel c makes channel (c+1) mod 4 the top rank on the next cycle. The others follow in cyclic order, with c last. Without a strobe the ranking is held.
- R4: A done strobe in round-robin mode for the channel that is already lowest-ranked leaves the ranking unchanged.
- R5: Leaving round-robin mode restores the ranking 0 > 1 > 2 > 3 on the next cycle, and a later entry into round-robin mode starts from that ranking.
- R6: When no grant is held, the next edge grants the highest-ranked channel among those requesting, using the ranking of the current cycle. The grant is one-hot, and it is zero when no channel requests.
- R7: While a grant is held and no done strobe arrives, the grant does not change, whatever the requests do.
- R8: A done strobe while a grant is held clears the grant on the next edge. Arbitration then resumes on the following edge with the updated ranking.
- R9: `cfg_err_o` is high, in the same cycle, exactly when round-robin is selected and the bits of `bus_mode_i` (1 = burst, 0 = cycle steal) are not all equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 4 | Per-channel transfer request |
| done_i | input | 1 | One-cycle strobe: a unit transfer finished |
| done_ch_i | input | 2 | Channel number that the done strobe refers to |
| mode_i | input | 2 | Priority scheme, 2'b01 round-robin, others fixed |
| bus_mode_i | input | 4 | Per-channel bus mode, 1 burst, 0 cycle steal |
| grant_o | output | 4 | One-hot grant, zero when idle |
| order_o | output | 8 | Current ranking, rank 0 in bits [1:0] |
| cfg_err_o | output | 1 | Mixed bus modes while round-robin is selected |

## Verification
On every cycle, the assertions check that the grant is one-hot and was issued to a channel that requested. They also check that the grant holds until the done strobe and drops right after it. For the ranking, they check that it stays at reset order in fixed mode, holds without a strobe, and puts the successor of the finishing channel on top in round-robin mode. The bench scenarios are what show the worked rotation sequences, the unchanged ranking when the lowest channel finishes, re-arbitration with the rotated order after a release, and the configuration-error flag against mixed and uniform bus modes.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the DMA channel priority arbiter.
// Assumes the channel count is a power of two so pointer arithmetic wraps.
package dma_arb_pkg;
    localparam int unsigned ARB_N_CH   = 4;
    localparam int unsigned ARB_CW     = $clog2(ARB_N_CH);
    localparam logic [1:0]  MODE_RR    = 2'b01;

    typedef logic [ARB_CW-1:0] arb_ch_t;
endpackage

// File: rtl/dma_arb_order.sv
`timescale 1ns/1ps
// Module: dma_arb_order
// Keeps the ranking as a pointer to the top-ranked channel and expands it
// into one channel number per rank. Round-robin completions move the
// pointer to the successor of the finishing channel; fixed mode pins it to 0.
// Assumes N_CH is a power of two (pointer addition wraps naturally).
module dma_arb_order #(
    parameter int unsigned N_CH = 4,
    localparam int unsigned CW  = $clog2(N_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rr_en_i,
    input  logic               done_i,
    input  logic [CW-1:0]      done_ch_i,
    output logic [CW-1:0]      top_o,
    output logic [N_CH*CW-1:0] order_o
);
    logic [CW-1:0] top_q;

    // Purpose: advance or reset the top-rank pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else if (!rr_en_i) begin
            top_q <= '0;
        end else if (done_i) begin
            top_q <= done_ch_i + 1'b1;
        end
    end

    assign top_o = top_q;

    // Purpose: expand the pointer into a per-rank channel list.
    for (genvar k = 0; k < N_CH; k++) begin : g_rank
        assign order_o[k*CW +: CW] = top_q + CW'(k);
    end
endmodule

// File: rtl/dma_arb_pick.sv
`timescale 1ns/1ps
// Module: dma_arb_pick
// Combinational search: returns a one-hot vector selecting the first
// requesting channel when scanning ranks from the top pointer downward.
// Assumes N_CH is a power of two.
module dma_arb_pick #(
    parameter int unsigned N_CH = 4,
    localparam int unsigned CW  = $clog2(N_CH)
) (
    input  logic [N_CH-1:0] req_i,
    input  logic [CW-1:0]   top_i,
    output logic [N_CH-1:0] pick_o
);
    logic [CW-1:0] idx;
    logic          found;

    // Purpose: scan ranks in order and mark the first requester.
    always_comb begin
        pick_o = '0;
        found  = 1'b0;
        idx    = '0;
        for (int k = 0; k < N_CH; k++) begin
            idx = top_i + CW'(k);
            if (!found && req_i[idx]) begin
                pick_o[idx] = 1'b1;
                found       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_arb_grant.sv
`timescale 1ns/1ps
// Module: dma_arb_grant
// Holds the grant for the duration of a unit transfer. When idle it loads
// the pick; when busy it keeps the grant until the done strobe clears it.
// Assumes the pick input is already one-hot or zero.
module dma_arb_grant #(
    parameter int unsigned N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] pick_i,
    input  logic            done_i,
    output logic [N_CH-1:0] grant_o
);
    logic [N_CH-1:0] grant_q;

    // Purpose: load, hold or release the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
        end else if (|grant_q) begin
            if (done_i) begin
                grant_q <= '0;
            end
        end else begin
            grant_q <= pick_i;
        end
    end

    assign grant_o = grant_q;
endmodule

// File: rtl/dma_prio_arb.sv
`timescale 1ns/1ps
// Module: dma_prio_arb (top)
// DMA channel priority arbiter with fixed and round-robin schemes. The
// ranking rotates on each completed unit transfer, not on each grant.
// Assumes done strobes are one cycle wide and name the granted channel.
module dma_prio_arb #(
    parameter int unsigned N_CH = dma_arb_pkg::ARB_N_CH,
    localparam int unsigned CW  = $clog2(N_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CH-1:0]    req_i,
    input  logic               done_i,
    input  logic [CW-1:0]      done_ch_i,
    input  logic [1:0]         mode_i,
    input  logic [N_CH-1:0]    bus_mode_i,
    output logic [N_CH-1:0]    grant_o,
    output logic [N_CH*CW-1:0] order_o,
    output logic               cfg_err_o
);
    logic            rr_en;
    logic [CW-1:0]   top;
    logic [N_CH-1:0] pick;

    assign rr_en = (mode_i == dma_arb_pkg::MODE_RR);

    dma_arb_order #(.N_CH(N_CH)) order_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rr_en_i   (rr_en),
        .done_i    (done_i),
        .done_ch_i (done_ch_i),
        .top_o     (top),
        .order_o   (order_o)
    );

    dma_arb_pick #(.N_CH(N_CH)) pick_i (
        .req_i  (req_i),
        .top_i  (top),
        .pick_o (pick)
    );

    dma_arb_grant #(.N_CH(N_CH)) grant_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pick_i  (pick),
        .done_i  (done_i),
        .grant_o (grant_o)
    );

    // Purpose: flag mixed burst/cycle-steal channels under round-robin.
    assign cfg_err_o = rr_en & ~((&bus_mode_i) | ~(|bus_mode_i));
endmodule

// File: rtl/dma_prio_arb_chk.sv
`timescale 1ns/1ps
// Module: dma_prio_arb_chk
// Property checker for dma_prio_arb, attached through bind below.
// Observes ports only.
module dma_prio_arb_chk #(
    parameter int unsigned N_CH = 4,
    localparam int unsigned CW  = $clog2(N_CH)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CH-1:0]    req_i,
    input logic               done_i,
    input logic [CW-1:0]      done_ch_i,
    input logic [1:0]         mode_i,
    input logic [N_CH-1:0]    grant_o,
    input logic [N_CH*CW-1:0] order_o
);
    a_r6_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    a_r6_grant_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o == '0) |=> (grant_o == '0 || (grant_o & $past(req_i)) != '0));

    a_r7_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && !done_i) |=> $stable(grant_o));

    a_r8_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && done_i) |=> (grant_o == '0));

    a_r3_rr_top: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == dma_arb_pkg::MODE_RR && done_i)
            |=> (order_o[CW-1:0] == CW'($past(done_ch_i) + 1'b1)));

    a_r3_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == dma_arb_pkg::MODE_RR && !done_i) |=> $stable(order_o));

    for (genvar k = 0; k < N_CH; k++) begin : g_fixed
        a_r2_fixed_order: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i != dma_arb_pkg::MODE_RR) |=> (order_o[k*CW +: CW] == CW'(k)));
    end
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.N_CH(N_CH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .done_i    (done_i),
    .done_ch_i (done_ch_i),
    .mode_i    (mode_i),
    .grant_o   (grant_o),
    .order_o   (order_o)
);

// File: tb/dma_prio_arb_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, compared
// against a behavioural model of the ranking and grant.
module dma_prio_arb_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_i = '0;
    logic       done_i = 1'b0;
    logic [1:0] done_ch_i = '0;
    logic [1:0] mode_i = '0;
    logic [3:0] bus_mode_i = '0;
    logic [3:0] grant_o;
    logic [7:0] order_o;
    logic       cfg_err_o;

    int checks = 0;
    int errors = 0;

    logic [1:0] m_top = '0;
    logic [3:0] m_grant = '0;

    always #10 clk = ~clk;

    dma_prio_arb dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_i(done_i),
        .done_ch_i(done_ch_i), .mode_i(mode_i), .bus_mode_i(bus_mode_i),
        .grant_o(grant_o), .order_o(order_o), .cfg_err_o(cfg_err_o)
    );

    function automatic logic [3:0] f_pick(logic [3:0] req, logic [1:0] top);
        for (int k = 0; k < 4; k++) begin
            logic [1:0] idx = top + 2'(k);
            if (req[idx]) return 4'(1 << idx);
        end
        return 4'b0;
    endfunction

    function automatic logic [7:0] f_order(logic [1:0] top);
        logic [7:0] o;
        for (int k = 0; k < 4; k++) o[k*2 +: 2] = top + 2'(k);
        return o;
    endfunction

    function automatic logic [1:0] f_id(logic [3:0] g);
        for (int k = 0; k < 4; k++) if (g[k]) return 2'(k);
        return 2'd0;
    endfunction

    function automatic logic f_cfg(logic [1:0] mode, logic [3:0] bm);
        return (mode == 2'b01) && (bm != 4'h0) && (bm != 4'hF);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, update model, compare at the next negedge.
    task automatic step(input logic [3:0] req, input logic done, input logic [1:0] ch,
                        input logic [1:0] mode, input logic [3:0] bm);
        string gtag, otag;
        req_i = req; done_i = done; done_ch_i = ch; mode_i = mode; bus_mode_i = bm;
        #1;
        check(cfg_err_o == f_cfg(mode, bm), "R9", 8'(cfg_err_o), 8'(f_cfg(mode, bm)));
        gtag = (m_grant == 0) ? "R6" : (done ? "R8" : "R7");
        otag = (mode != 2'b01) ? "R2" : "R3";
        if (m_grant != 0) begin
            if (done) m_grant = '0;
        end else begin
            m_grant = f_pick(req, m_top);
        end
        m_top = (mode != 2'b01) ? 2'd0 : (done ? ch + 2'd1 : m_top);
        @(negedge clk);
        check(grant_o == m_grant, gtag, 8'(grant_o), 8'(m_grant));
        check(order_o == f_order(m_top), otag, order_o, f_order(m_top));
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        check(grant_o == 4'h0, "R1", 8'(grant_o), 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check(grant_o == 4'h0, "R1", 8'(grant_o), 8'h00);
        check(order_o == 8'hE4, "R1", order_o, 8'hE4);

        // R3: worked rotation sequence
        step(4'h0, 1'b1, 2'd2, 2'b01, 4'h0);
        check(order_o == 8'h93, "R3", order_o, 8'h93);
        step(4'h0, 1'b1, 2'd1, 2'b01, 4'h0);
        check(order_o == 8'h4E, "R3", order_o, 8'h4E);
        // R5: leaving round-robin restores reset order
        step(4'h0, 1'b0, 2'd0, 2'b00, 4'h0);
        check(order_o == 8'hE4, "R5", order_o, 8'hE4);
        step(4'h0, 1'b0, 2'd0, 2'b01, 4'h0);
        check(order_o == 8'hE4, "R5", order_o, 8'hE4);
        // R4: lowest channel completes
        step(4'h0, 1'b1, 2'd3, 2'b01, 4'h0);
        check(order_o == 8'hE4, "R4", order_o, 8'hE4);
        // R2: fixed mode ignores done, reserved encodings are fixed
        step(4'h0, 1'b1, 2'd1, 2'b00, 4'h0);
        check(order_o == 8'hE4, "R2", order_o, 8'hE4);
        step(4'h0, 1'b1, 2'd0, 2'b11, 4'h0);
        check(order_o == 8'hE4, "R2", order_o, 8'hE4);

        // R6/R7/R8 grant sequence in round-robin
        step(4'b1010, 1'b0, 2'd0, 2'b01, 4'h0);
        check(grant_o == 4'b0010, "R6", 8'(grant_o), 8'h02);
        step(4'b0001, 1'b0, 2'd0, 2'b01, 4'h0);
        check(grant_o == 4'b0010, "R7", 8'(grant_o), 8'h02);
        step(4'b1010, 1'b1, 2'd1, 2'b01, 4'h0);
        check(grant_o == 4'b0000, "R8", 8'(grant_o), 8'h00);
        step(4'b1010, 1'b0, 2'd0, 2'b01, 4'h0);
        check(grant_o == 4'b1000, "R8", 8'(grant_o), 8'h08);
        step(4'b0000, 1'b1, 2'd3, 2'b01, 4'h0);
        step(4'b0000, 1'b0, 2'd0, 2'b01, 4'h0);
        check(grant_o == 4'b0000, "R6", 8'(grant_o), 8'h00);

        // R9: configuration error flag
        step(4'h0, 1'b0, 2'd0, 2'b01, 4'b0101);
        step(4'h0, 1'b0, 2'd0, 2'b01, 4'b1111);
        step(4'h0, 1'b0, 2'd0, 2'b00, 4'b0101);

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] md;
            logic       dn;
            logic [1:0] ch;
            md = ($urandom % 8 == 0) ? 2'($urandom % 4) : 2'b01;
            if (m_grant != 0 && ($urandom % 5) < 2) begin
                dn = 1'b1; ch = f_id(m_grant);
            end else begin
                dn = ($urandom % 20 == 0); ch = 2'($urandom % 4);
            end
            step(4'($urandom), dn, ch, md, 4'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule